// File: doc/BRIEF.md
# Multiplierless Transposed FIR Filter

This block is an eight-tap, full-rate low-pass FIR filter with fixed coefficients. Each clock it can take one signed 16-bit sample. One clock later it returns one filtered result. It never decimates or interpolates.

The filter contains no multipliers. Each incoming sample goes into one small network of shifts, adds and subtracts. Every coefficient is written in canonical signed digit form, and partial sums are shared between coefficients. As a result, all coefficient products of the current sample are available in the same cycle.

Those products feed a transposed chain of registered adders. The last stage of the chain is the output register. A valid strobe on the input moves the chain forward, and a matching strobe on the output marks each new result.

Top module: `fir_csd_transposed`

## Requirements
- R1: For each clock edge at which `in_valid` is 1, `out_valid` is 1 in the following cycle. After an edge with `in_valid` at 0, `out_valid` is 0 in the following cycle.
- R2: The result that `out_valid` marks equals y[n] = sum over k=0..7 of h[k]·x[n-k], with h = {3, -5, 12, 38, 38, 12, -5, 3}. Here x[n] is the sample accepted at that edge, x[n-k] is the sample accepted k strobes earlier, and samples before the first one (or before a reset) count as 0.
- R3: `out_data` is signed and 23 bits wide. Any run of full-scale inputs (+32767 or -32768) gives the exact result with no wrap.
- R4: Every coefficient product in the shared network equals the coefficient times the sign-extended input, although it is built only from shifts and adds.
- R5: While `in_valid` is 0, `out_data` keeps its value and the filter history is unchanged. Idle gaps do not change the result sequence of the accepted samples.
- R6: A synchronous reset (`rst` = 1 at a clock edge) clears `out_valid`, `out_data` and the whole filter history to zero.
- R7: A single sample of value 1 followed by zeros produces the coefficients 3, -5, 12, 38, 38, 12, -5, 3 on eight consecutive results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; moves the chain forward |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | High for one cycle per accepted sample |
| out_data | output | 23 | Signed filtered result |

## Verification
Each result is due exactly one cycle after the edge that accepts its sample. The driver changes inputs on the falling edge and pushes the expected value, computed by direct-form convolution, into a queue. The monitor samples on the next falling edge and pops one expected value each time `out_valid` is high. While `out_valid` is low, the monitor checks that `out_data` holds its previous value. This holds the timing to a single cycle, so an extra or missing register stage, or a strobe without a matching sample, shows up as a mismatch or as a non-empty queue.

// File: rtl/fir_csd_transposed.sv
module fir_csd_transposed #(
  parameter int DW = 16,
  localparam int TAPS = 8,
  localparam int AW = DW + $clog2(116)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_data
);

  logic signed [AW-1:0] xs, t3, t5, p12, p38;
  logic signed [AW-1:0] prod [TAPS];
  logic signed [AW-1:0] st   [TAPS];

  assign xs  = {{(AW-DW){in_data[DW-1]}}, in_data};
  assign t3  = (xs <<< 2) - xs;
  assign t5  = (xs <<< 2) + xs;
  assign p12 = t3 <<< 2;
  assign p38 = (t5 <<< 3) - (xs <<< 1);

  assign prod[0] = t3;
  assign prod[1] = -t5;
  assign prod[2] = p12;
  assign prod[3] = p38;
  assign prod[4] = p38;
  assign prod[5] = p12;
  assign prod[6] = -t5;
  assign prod[7] = t3;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= '{default: '0};
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        st[0] <= prod[0];
        for (int k = 1; k < TAPS; k++) st[k] <= st[k-1] + prod[k];
      end
    end
  end

  assign out_data = st[TAPS-1];

  localparam logic signed [AW-1:0] C3  = AW'(3);
  localparam logic signed [AW-1:0] C5  = AW'(5);
  localparam logic signed [AW-1:0] C12 = AW'(12);
  localparam logic signed [AW-1:0] C38 = AW'(38);

  AST_PROD_EXACT: assert property (@(posedge clk) disable iff (rst)
    (t3 == xs * C3) && (t5 == xs * C5) && (p12 == xs * C12) && (p38 == xs * C38)); // R4
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data)); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0)); // R6

endmodule

// File: tb/test_fir_csd_transposed.sv
module test_fir_csd_transposed;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [22:0] out_data;

  int checks = 0;
  int failures = 0;
  int hist [8];
  int exp_q [$];
  string tag_q [$];
  int coef [8] = '{3, -5, 12, 38, 38, 12, -5, 3};
  int last_out = 0;

  always #2 clk = ~clk;

  fir_csd_transposed i_fir_csd_transposed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic send(input int x, input string tag);
    int acc = 0;
    @(negedge clk);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    for (int k = 0; k < 8; k++) acc += coef[k] * hist[k];
    exp_q.push_back(acc);
    tag_q.push_back(tag);
    in_valid = 1'b1;
    in_data = 16'(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data = 16'h5a5a;
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      last_out = 0;
    end else if (out_valid) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected out_valid", 1, 0);
      end else begin
        check(tag_q.pop_front(), int'(out_data), exp_q.pop_front());
      end
      last_out = int'(out_data);
    end else begin
      check("R5 hold while idle", int'(out_data), last_out);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    for (int k = 0; k < 8; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    check("R6 reset out_valid", int'(out_valid), 0);
    check("R6 reset out_data", int'(out_data), 0);
    @(negedge clk);
    rst = 1'b0;

    send(1, "R7 impulse");
    for (int i = 0; i < 9; i++) send(0, "R7 impulse tail");
    idle(2);

    for (int i = 0; i < 12; i++) send(1000, "R2 step");
    idle(1);

    for (int i = 0; i < 10; i++) send(32767, "R3 full-scale positive");
    for (int i = 0; i < 10; i++) send(-32768, "R3 full-scale negative");
    for (int i = 0; i < 6; i++) begin
      send(32767, "R3 alternating full-scale");
      send(-32768, "R3 alternating full-scale");
    end
    idle(2);

    for (int i = 0; i < 200; i++) begin
      send($signed(16'($urandom)), "R2 random");
      if (($urandom % 4) == 0) idle(1 + ($urandom % 3)); // R5 gaps
    end
    idle(3);
    check("R1 queue drained", exp_q.size(), 0);

    for (int i = 0; i < 5; i++) send(12345 - i * 7000, "R2 before reset");
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 8; k++) hist[k] = 0;
    @(negedge clk);
    @(negedge clk);
    check("R6 mid-run reset out_valid", int'(out_valid), 0);
    check("R6 mid-run reset out_data", int'(out_data), 0);
    rst = 1'b0;
    send(-1, "R6 history cleared impulse");
    for (int i = 0; i < 8; i++) send(0, "R6 history cleared tail");
    idle(3);
    check("R1 final queue drained", exp_q.size(), 0);
    summary();
  end
endmodule